// File: doc/BRIEF.md
# Dual Stack Register Cache

This block holds the topmost entries of two stacks, an operand stack and a return-address stack, in one register file. The file is split into two equal regions, one per stack. Software never names a physical register. Every read and write gives a small offset from the top of the currently selected stack, and the block turns that offset into a physical entry through the stack pointer of that stack. Offset 0 is the top entry and offset 1 is the entry just below it.

Push and pop commands move the active pointer one 32-bit entry (4 bytes) at a time. A push moves the pointer down, so the old top is then found at offset 1. A select command swaps stacks. The outgoing pointer is parked in that stack's shadow register and the incoming stack's shadow value becomes the live pointer, which the block drives out as a byte address. The block keeps an occupancy count for each stack. It raises a one-cycle warning when a push brings the count close to the region size, and another when a pop brings it close to empty. Moving entries to or from memory is left to software, which acts on those warnings.

Top module: `dual_stack_cache`

## Requirements
- R1: After a synchronous reset, the operand stack (act_o = 0) is selected, sp_o reads 0x000, the return stack's parked pointer is 0x100, both occupancy counts are 0 and both warnings are low.
- R2: A read port returns the entry at physical index {active stack bit, (sp_o[7:2] + offset) mod 64}. Offset 0 is the top of the active stack.
- R3: A lone push lowers sp_o by 4 and a lone pop raises it by 4. The 6-bit slot field sp_o[7:2] wraps modulo 64, while sp_o[8] always equals act_o and sp_o[1:0] stays 0.
- R4: A write in the same cycle as a push or pop lands at the post-move pointer plus the write offset, so push with a write at offset 0 makes the new value the top.
- R5: Selecting the other stack parks the current pointer and restores that stack's own pointer. Entries of one region are never seen through the other.
- R6: Push and pop together leave pointer and occupancy unchanged (a write still happens), and selecting the already-active stack changes nothing.
- R7: Each stack has an occupancy count, visible for the active stack on occ_o. It is raised by a push, lowered by a pop and held within 0..64.
- R8: spill_irq_o is high for exactly the cycle after a push whose resulting occupancy is 62 or more.
- R9: fill_irq_o is high for exactly the cycle after a pop whose resulting occupancy is 1 or less (including a pop at 0).
- R10: A push, pop or write issued in the same cycle as a stack change acts on the outgoing stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Move active pointer down one entry |
| pop_i | input | 1 | Move active pointer up one entry |
| sel_we_i | input | 1 | Apply stack selection this cycle |
| sel_i | input | 1 | Stack to select: 0 operand, 1 return |
| wr_en_i | input | 1 | Write enable |
| wr_off_i | input | 6 | Write offset from post-move top |
| wr_data_i | input | 32 | Write data |
| rd_off_a_i | input | 6 | Read port A offset from top |
| rd_data_a_o | output | 32 | Read port A data (combinational) |
| rd_off_b_i | input | 6 | Read port B offset from top |
| rd_data_b_o | output | 32 | Read port B data (combinational) |
| sp_o | output | 9 | Active stack pointer as byte address |
| act_o | output | 1 | Currently selected stack |
| occ_o | output | 7 | Occupancy of the active stack |
| spill_irq_o | output | 1 | Near-full warning pulse |
| fill_irq_o | output | 1 | Near-empty warning pulse |

## Verification
The bench leads the pointer across the slot wrap from 0x0FC to 0x000 and then reads a value written before the wrap. A design that carried the wrap into the region bit would read the wrong region or drift into the other stack. It switches stacks in the same cycle as a push with a write and then switches back. An implementation that applied that push to the incoming stack, or parked the pre-push pointer, would show the wrong top and pointer. It drives the operand count up to the saturation point and past it, and takes it down through 1 and 0 with one extra pop. This catches off-by-one warning thresholds, a counter that wraps instead of saturating, and warnings held longer than one cycle. Simultaneous push and pop, and reselection of the active stack, must leave the pointer still.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int unsigned ENTRY_W      = 32;
    localparam int unsigned REGION_DEPTH = 64;
    localparam int unsigned NUM_STACKS   = 2;
    localparam int unsigned SLOT_W       = $clog2(REGION_DEPTH);
    localparam int unsigned IDX_W        = SLOT_W + $clog2(NUM_STACKS);
    localparam int unsigned SP_W         = IDX_W + 2;
    localparam int unsigned OCC_W        = $clog2(REGION_DEPTH + 1);
    localparam int unsigned NUM_REGS     = NUM_STACKS * REGION_DEPTH;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [OCC_W-1:0]  occ_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [SP_W-1:0]   sp_t;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_PUSH = 2'd1,
        MV_POP  = 2'd2
    } move_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic sel_we;
        logic sel;
    } stk_cmd_t;

    function automatic move_e decode_move(stk_cmd_t c);
        if (c.push && !c.pop) return MV_PUSH;
        if (c.pop && !c.push) return MV_POP;
        return MV_HOLD;
    endfunction

    function automatic slot_t step_slot(slot_t s, move_e m);
        case (m)
            MV_PUSH: return s - slot_t'(1);
            MV_POP:  return s + slot_t'(1);
            default: return s;
        endcase
    endfunction

    function automatic occ_t step_occ(occ_t o, move_e m);
        case (m)
            MV_PUSH: return (o == occ_t'(REGION_DEPTH)) ? o : o + occ_t'(1);
            MV_POP:  return (o == '0) ? o : o - occ_t'(1);
            default: return o;
        endcase
    endfunction

    function automatic idx_t map_index(logic stk, slot_t s, slot_t off);
        slot_t sum;
        sum = s + off;
        return {stk, sum};
    endfunction

    function automatic sp_t byte_addr(logic stk, slot_t s);
        return {stk, s, 2'b00};
    endfunction

endpackage

// File: rtl/dsc_ptr_unit.sv
module dsc_ptr_unit
    import dsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  stk_cmd_t cmd_i,
    output logic     act_o,
    output slot_t    cur_slot_o,
    output slot_t    post_slot_o,
    output move_e    move_o,
    output occ_t     occ_post_o,
    output occ_t     act_occ_o
);

    logic  act_q;
    slot_t slot_q;
    slot_t shadow_v [NUM_STACKS];
    occ_t  occ_v    [NUM_STACKS];

    move_e mv;
    logic  swap;
    slot_t slot_moved;
    occ_t  occ_moved;

    always_comb begin
        mv         = decode_move(cmd_i);
        swap       = cmd_i.sel_we && (cmd_i.sel != act_q);
        slot_moved = step_slot(slot_q, mv);
        occ_moved  = step_occ(occ_v[act_q], mv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            slot_q <= '0;
        end else if (swap) begin
            act_q  <= cmd_i.sel;
            slot_q <= shadow_v[cmd_i.sel];
        end else begin
            slot_q <= slot_moved;
        end
    end

    for (genvar g = 0; g < NUM_STACKS; g++) begin : g_stk
        localparam logic STK_ID = 1'(g);
        slot_t shadow_q;
        occ_t  occ_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
                occ_q    <= '0;
            end else begin
                if (swap && act_q == STK_ID) shadow_q <= slot_moved;
                if (act_q == STK_ID)         occ_q    <= occ_moved;
            end
        end

        assign shadow_v[g] = shadow_q;
        assign occ_v[g]    = occ_q;
    end

    assign act_o       = act_q;
    assign cur_slot_o  = slot_q;
    assign post_slot_o = slot_moved;
    assign move_o      = mv;
    assign occ_post_o  = occ_moved;
    assign act_occ_o   = occ_v[act_q];

endmodule

// File: rtl/dsc_regfile.sv
module dsc_regfile #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     ra_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [AW-1:0]     rb_idx_i,
    output logic [DATA_W-1:0] rb_data_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[widx_i] <= wdata_i;
    end

    assign ra_data_o = mem[ra_idx_i];
    assign rb_data_o = mem[rb_idx_i];

endmodule

// File: rtl/dsc_warn.sv
module dsc_warn
    import dsc_pkg::*;
#(
    parameter int unsigned SPILL_MARK = 62,
    parameter int unsigned FILL_MARK  = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  move_e move_i,
    input  occ_t  occ_post_i,
    output logic  spill_o,
    output logic  fill_o
);

    localparam occ_t SPILL_LVL = occ_t'(SPILL_MARK);
    localparam occ_t FILL_LVL  = occ_t'(FILL_MARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            spill_o <= 1'b0;
            fill_o  <= 1'b0;
        end else begin
            spill_o <= (move_i == MV_PUSH) && (occ_post_i >= SPILL_LVL);
            fill_o  <= (move_i == MV_POP)  && (occ_post_i <= FILL_LVL);
        end
    end

endmodule

// File: rtl/dual_stack_cache.sv
module dual_stack_cache
    import dsc_pkg::*;
#(
    parameter int unsigned DATA_W     = dsc_pkg::ENTRY_W,
    parameter int unsigned SPILL_MARK = 62,
    parameter int unsigned FILL_MARK  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              sel_we_i,
    input  logic              sel_i,
    input  logic              wr_en_i,
    input  logic [5:0]        wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [5:0]        rd_off_a_i,
    output logic [DATA_W-1:0] rd_data_a_o,
    input  logic [5:0]        rd_off_b_i,
    output logic [DATA_W-1:0] rd_data_b_o,
    output logic [8:0]        sp_o,
    output logic              act_o,
    output logic [6:0]        occ_o,
    output logic              spill_irq_o,
    output logic              fill_irq_o
);

    stk_cmd_t cmd;
    logic     act;
    slot_t    cur_slot;
    slot_t    post_slot;
    move_e    mv;
    occ_t     occ_post;
    occ_t     act_occ;
    idx_t     widx;
    idx_t     ra_idx;
    idx_t     rb_idx;

    assign cmd = '{push: push_i, pop: pop_i, sel_we: sel_we_i, sel: sel_i};

    dsc_ptr_unit u_ptr (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .act_o       (act),
        .cur_slot_o  (cur_slot),
        .post_slot_o (post_slot),
        .move_o      (mv),
        .occ_post_o  (occ_post),
        .act_occ_o   (act_occ)
    );

    always_comb begin
        widx   = map_index(act, post_slot, slot_t'(wr_off_i));
        ra_idx = map_index(act, cur_slot, slot_t'(rd_off_a_i));
        rb_idx = map_index(act, cur_slot, slot_t'(rd_off_b_i));
    end

    dsc_regfile #(
        .DATA_W (DATA_W),
        .DEPTH  (NUM_REGS)
    ) u_rf (
        .clk       (clk),
        .we_i      (wr_en_i),
        .widx_i    (widx),
        .wdata_i   (wr_data_i),
        .ra_idx_i  (ra_idx),
        .ra_data_o (rd_data_a_o),
        .rb_idx_i  (rb_idx),
        .rb_data_o (rd_data_b_o)
    );

    dsc_warn #(
        .SPILL_MARK (SPILL_MARK),
        .FILL_MARK  (FILL_MARK)
    ) u_warn (
        .clk        (clk),
        .rst        (rst),
        .move_i     (mv),
        .occ_post_i (occ_post),
        .spill_o    (spill_irq_o),
        .fill_o     (fill_irq_o)
    );

    assign sp_o  = byte_addr(act, cur_slot);
    assign act_o = act;
    assign occ_o = act_occ;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       push_i,
    input logic       pop_i,
    input logic       sel_we_i,
    input logic       sel_i,
    input logic [8:0] sp_o,
    input logic       act_o,
    input logic [6:0] occ_o,
    input logic       spill_irq_o,
    input logic       fill_irq_o
);

    logic sw_req;
    assign sw_req = sel_we_i && (sel_i != act_o);

    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        sp_o[1:0] == 2'b00); // R3

    AST_REGION_MATCH: assert property (@(posedge clk) disable iff (rst)
        sp_o[8] == act_o); // R5

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !sw_req) |=>
        (sp_o == {$past(sp_o[8]), 6'($past(sp_o[7:2]) - 6'd1), 2'b00})); // R3

    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !sw_req) |=>
        (sp_o == {$past(sp_o[8]), 6'($past(sp_o[7:2]) + 6'd1), 2'b00})); // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (push_i == pop_i && !sw_req) |=> $stable(sp_o) && $stable(act_o)); // R6

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ_o <= 7'(REGION_DEPTH)); // R7

    AST_SPILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        spill_irq_o |-> $past(push_i && !pop_i)); // R8

    AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fill_irq_o |-> $past(pop_i && !push_i)); // R9

    AST_WARN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(spill_irq_o && fill_irq_o)); // R8

endmodule

bind dual_stack_cache dsc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .sel_we_i    (sel_we_i),
    .sel_i       (sel_i),
    .sp_o        (sp_o),
    .act_o       (act_o),
    .occ_o       (occ_o),
    .spill_irq_o (spill_irq_o),
    .fill_irq_o  (fill_irq_o)
);

// File: tb/dual_stack_cache_tb_top.sv
module dual_stack_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 0, pop_i = 0, sel_we_i = 0, sel_i = 0, wr_en_i = 0;
    logic [5:0]  wr_off_i = '0, rd_off_a_i = '0, rd_off_b_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_a_o, rd_data_b_o;
    logic [8:0]  sp_o;
    logic        act_o;
    logic [6:0]  occ_o;
    logic        spill_irq_o, fill_irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_stack_cache dut_i (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .sel_we_i(sel_we_i), .sel_i(sel_i), .wr_en_i(wr_en_i),
        .wr_off_i(wr_off_i), .wr_data_i(wr_data_i),
        .rd_off_a_i(rd_off_a_i), .rd_data_a_o(rd_data_a_o),
        .rd_off_b_i(rd_off_b_i), .rd_data_b_o(rd_data_b_o),
        .sp_o(sp_o), .act_o(act_o), .occ_o(occ_o),
        .spill_irq_o(spill_irq_o), .fill_irq_o(fill_irq_o)
    );

    typedef struct packed {
        logic        push, pop, sw, sel, we;
        logic [5:0]  woff;
        logic [31:0] wd;
        logic [5:0]  ra, rb;
        logic        ca;
        logic [31:0] ea;
        logic        cb;
        logic [31:0] eb;
        logic [8:0]  sp;
        logic [6:0]  occ;
        logic        act;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1,0,0,0,1, 6'd0, 32'h11, 6'd0,6'd0, 1,32'h11, 0,32'h0,  9'h0FC,7'd1,0},
        '{1,0,0,0,1, 6'd0, 32'h22, 6'd0,6'd1, 1,32'h22, 1,32'h11, 9'h0F8,7'd2,0},
        '{1,0,0,0,1, 6'd0, 32'h33, 6'd0,6'd2, 1,32'h33, 1,32'h11, 9'h0F4,7'd3,0},
        '{0,0,0,0,1, 6'd1, 32'h44, 6'd1,6'd0, 1,32'h44, 1,32'h33, 9'h0F4,7'd3,0},
        '{0,1,0,0,0, 6'd0, 32'h0,  6'd0,6'd1, 1,32'h44, 1,32'h11, 9'h0F8,7'd2,0},
        '{0,0,1,1,0, 6'd0, 32'h0,  6'd0,6'd0, 0,32'h0,  0,32'h0,  9'h100,7'd0,1},
        '{1,0,0,0,1, 6'd0, 32'hA1, 6'd0,6'd0, 1,32'hA1, 0,32'h0,  9'h1FC,7'd1,1},
        '{1,0,0,0,1, 6'd0, 32'hA2, 6'd0,6'd1, 1,32'hA2, 1,32'hA1, 9'h1F8,7'd2,1},
        '{0,0,1,0,0, 6'd0, 32'h0,  6'd0,6'd1, 1,32'h44, 1,32'h11, 9'h0F8,7'd2,0},
        '{1,0,1,1,1, 6'd0, 32'h55, 6'd0,6'd1, 1,32'hA2, 1,32'hA1, 9'h1F8,7'd2,1},
        '{0,0,1,0,0, 6'd0, 32'h0,  6'd0,6'd1, 1,32'h55, 1,32'h44, 9'h0F4,7'd3,0},
        '{0,1,0,0,0, 6'd0, 32'h0,  6'd0,6'd1, 1,32'h44, 1,32'h11, 9'h0F8,7'd2,0},
        '{1,1,0,0,1, 6'd0, 32'h99, 6'd0,6'd1, 1,32'h99, 1,32'h11, 9'h0F8,7'd2,0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic pu, input logic po, input logic sw, input logic sl,
                       input logic we, input logic [5:0] wo, input logic [31:0] wd);
        push_i = pu; pop_i = po; sel_we_i = sw; sel_i = sl;
        wr_en_i = we; wr_off_i = wo; wr_data_i = wd;
        @(posedge clk);
        @(negedge clk);
        push_i = 0; pop_i = 0; sel_we_i = 0; sel_i = 0; wr_en_i = 0;
        wr_off_i = '0; wr_data_i = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 sp", 32'(sp_o), 32'h000);
        chk("R1 act", 32'(act_o), 32'h0);
        chk("R1 occ", 32'(occ_o), 32'h0);
        chk("R1 spill", 32'(spill_irq_o), 32'h0);
        chk("R1 fill", 32'(fill_irq_o), 32'h0);

        // Table: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            rd_off_a_i = VECS[i].ra;
            rd_off_b_i = VECS[i].rb;
            cyc(VECS[i].push, VECS[i].pop, VECS[i].sw, VECS[i].sel,
                VECS[i].we, VECS[i].woff, VECS[i].wd);
            #1;
            if (VECS[i].ca) chk($sformatf("R2 R4 R10 vec%0d port A", i), rd_data_a_o, VECS[i].ea);
            if (VECS[i].cb) chk($sformatf("R2 R4 R10 vec%0d port B", i), rd_data_b_o, VECS[i].eb);
            chk($sformatf("R3 R5 vec%0d sp", i), 32'(sp_o), 32'(VECS[i].sp));
            chk($sformatf("R7 vec%0d occ", i), 32'(occ_o), 32'(VECS[i].occ));
            chk($sformatf("R5 vec%0d act", i), 32'(act_o), 32'(VECS[i].act));
        end

        // Slot wrap and fill warning: operand at slot 62, occupancy 2
        cyc(0,0,0,0,1, 6'd5, 32'h77);           // lands in slot 3
        cyc(0,1,0,0,0, 6'd0, 32'h0);
        chk("R9 fill at occ1", 32'(fill_irq_o), 32'h1);
        chk("R3 sp 0FC", 32'(sp_o), 32'h0FC);
        cyc(0,1,0,0,0, 6'd0, 32'h0);
        chk("R9 fill at occ0", 32'(fill_irq_o), 32'h1);
        chk("R3 wrap to 000", 32'(sp_o), 32'h000);
        cyc(0,0,0,0,0, 6'd0, 32'h0);
        chk("R9 fill one cycle", 32'(fill_irq_o), 32'h0);
        rd_off_a_i = 6'd3; #1;
        chk("R2 read across wrap", rd_data_a_o, 32'h77);
        cyc(0,1,0,0,0, 6'd0, 32'h0);
        chk("R7 occ floor", 32'(occ_o), 32'h0);
        chk("R9 fill pop at 0", 32'(fill_irq_o), 32'h1);
        chk("R3 sp 004", 32'(sp_o), 32'h004);
        cyc(0,0,1,0,0, 6'd0, 32'h0);            // reselect active stack
        chk("R6 same select sp", 32'(sp_o), 32'h004);
        chk("R6 same select act", 32'(act_o), 32'h0);

        // Spill warning and saturation from reset
        do_reset();
        chk("R1 sp after rerun", 32'(sp_o), 32'h000);
        for (int k = 0; k < 61; k++) cyc(1,0,0,0,0, 6'd0, 32'h0);
        chk("R7 occ 61", 32'(occ_o), 32'd61);
        chk("R8 no spill at 61", 32'(spill_irq_o), 32'h0);
        cyc(1,0,0,0,0, 6'd0, 32'h0);
        chk("R8 spill at 62", 32'(spill_irq_o), 32'h1);
        cyc(1,0,0,0,0, 6'd0, 32'h0);
        cyc(1,0,0,0,0, 6'd0, 32'h0);
        chk("R7 occ 64", 32'(occ_o), 32'd64);
        cyc(1,0,0,0,1, 6'd0, 32'hBEEF);
        chk("R7 occ ceiling", 32'(occ_o), 32'd64);
        chk("R8 spill at ceiling", 32'(spill_irq_o), 32'h1);
        chk("R3 sp after 65 pushes", 32'(sp_o), 32'h0FC);
        rd_off_a_i = 6'd0; #1;
        chk("R4 top after wrap push", rd_data_a_o, 32'hBEEF);
        cyc(0,0,0,0,0, 6'd0, 32'h0);
        chk("R8 spill one cycle", 32'(spill_irq_o), 32'h0);
        cyc(0,0,1,1,0, 6'd0, 32'h0);
        chk("R1 return sp parked", 32'(sp_o), 32'h100);
        chk("R7 return occ separate", 32'(occ_o), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule